// File: doc/BRIEF.md
# Keyboard Character Serial Transmitter

This block accepts one parallel character from a keyboard encoder and sends it as a timed serial frame on a communications line. A frame has a low start bit, the data bits least significant first, and a trailing check bit. It is followed by a return of the line to its idle high level. All timing is counted in ticks of a shared tick enable, so one system clock can serve any line rate.

A character is taken in only when no cycle is running and both the keyboard-ready and link-ready inputs are high on a tick. The shift register is then forced to all ones for a short preset pulse. At the end of that pulse, every position whose data value is zero is cleared, and positions holding a one are left set. A bit clock then runs with a short high pulse at the start of each bit period. Shift pulses are issued only while the cycle is active and that clock pulse is high. Zeros are shifted in behind the data. Once the register has emptied, the check bit is injected into the line. The cycle ends when the check bit stands at the output gate and the next clock pulse arrives while the cycle timer is still live.

Top module: `keychar_serial_tx`

## Requirements
- R1: After reset, `line_out` is 1, `cycle_busy` is 0 and `reg_empty` is 1.
- R2: A character is loaded on a tick where `cycle_busy` is 0 and `kbd_ready` and `link_ready` are both 1. After that tick, `cycle_busy` is 1 and `char_in` has been captured.
- R3: While `link_ready` is 0, no cycle starts, whatever `kbd_ready` does.
- R4: `line_out` stays 1 for the load tick and the RST_TICKS preset ticks that follow it. On the next tick it drives the start bit, value 0, for BIT_TICKS ticks.
- R5: After the start bit, data bits follow with `char_in[0]` first, each held for BIT_TICKS ticks. A 0 in the character gives a 0 on the line, and a 1 gives a 1.
- R6: After the last data bit, the check bit is held for BIT_TICKS ticks. Its value is the XOR of all data bits, XORed with PARITY_ODD.
- R7: `reg_empty` falls on the load tick. It rises on the tick that shifts the last data bit out of the register, and it is 1 whenever `cycle_busy` is 0.
- R8: The cycle ends on the first clock pulse after the check bit has been held for a full bit period, that is RST_TICKS+1+(DATA_W+2)*BIT_TICKS ticks after the load tick. On that tick `cycle_busy` falls and `line_out` returns to 1. It happens only while the check bit is at the gate and the bit clock is high, and `line_out` is 1 whenever `cycle_busy` is 0.
- R9: While a cycle is active, `kbd_ready` and `char_in` have no effect on the frame being sent. If `kbd_ready` is still high, the next character loads on the first tick after `cycle_busy` falls.
- R10: On a clock edge with `tick_en` low, `line_out`, `cycle_busy` and `reg_empty` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base tick; all timing advances only on edges where it is high |
| kbd_ready | input | 1 | Keyboard reports a character ready on `char_in` |
| link_ready | input | 1 | Line is ready to accept a new character |
| char_in | input | DATA_W | Parallel character from the keyboard encoder |
| line_out | output | 1 | Serial data line, idle high |
| cycle_busy | output | 1 | A transmit cycle is in progress |
| reg_empty | output | 1 | Shift register holds no unsent data bits |

## Verification
Two events can fall in the same cycle. The stop of one cycle and the start of the next meet when `kbd_ready` is held high across a whole frame with a different `char_in` presented. The bench checks that the running frame still carries the first character, that `cycle_busy` falls exactly on the stop tick, and that the second character loads on the very next tick. The check-bit injection and the stop pulse both key off the bit-clock rise, so the bench measures the check bit's hold time and the stop tick to confirm they fall one full bit period apart. Random gaps in `tick_en` move these coincidences onto arbitrary clock edges.

// File: rtl/kst_pkg.sv
package kst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRESET = 2'd1,
        ST_SHIFT  = 2'd2
    } cyc_state_e;

    // Strobes from the cycle controller to the shift datapath; each is
    // qualified by a tick.
    typedef struct packed {
        logic load;    // capture the parallel character
        logic preset;  // drive every register bit to one, clear check bit
        logic clear;   // clear zero positions, compute the check bit
        logic shift;   // move one bit toward the line
        logic stop;    // end of cycle, line back to idle
    } sr_ctrl_t;

    localparam int unsigned MAX_DATA_W = 16;

    function automatic logic check_bit(input logic [MAX_DATA_W-1:0] d,
                                       input int unsigned w,
                                       input logic odd);
        logic r;
        r = odd;
        for (int i = 0; i < MAX_DATA_W; i++) begin
            if (i < int'(w)) r = r ^ d[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/kst_bit_clock.sv
module kst_bit_clock #(
    parameter int unsigned BIT_TICKS   = 8,
    parameter int unsigned PULSE_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic run,
    output logic clk_hi,
    output logic clk_rise
);
    localparam int unsigned PH_W = (BIT_TICKS > 2) ? $clog2(BIT_TICKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_TICKS - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else if (tick_en) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    always_comb begin
        clk_hi   = run && (int'(phase) < int'(PULSE_TICKS));
        clk_rise = run && (phase == '0);
    end

endmodule

// File: rtl/kst_cycle_ctrl.sv
module kst_cycle_ctrl
    import kst_pkg::*;
#(
    parameter int unsigned RST_TICKS = 3,
    parameter int unsigned BIT_TICKS = 8,
    parameter int unsigned FRAME_W   = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_en,
    input  logic     kbd_ready,
    input  logic     link_ready,
    input  logic     clk_hi,
    input  logic     clk_rise,
    input  logic     check_at_gate,
    output logic     cycle_busy,
    output logic     run,
    output sr_ctrl_t ctl
);
    // Longest legal cycle, counted from the load tick.
    localparam int unsigned CYC_TICKS = RST_TICKS + 2 + (FRAME_W + 1) * BIT_TICKS;
    localparam int unsigned TC_W      = $clog2(CYC_TICKS + 1);
    localparam int unsigned RC_W      = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_TICKS - 1);
    localparam logic [TC_W-1:0] TC_LIM  = TC_W'(CYC_TICKS);

    cyc_state_e      state;
    logic [RC_W-1:0] rcnt;
    logic [TC_W-1:0] tcnt;
    logic            timer_live;
    logic            stop_hit;
    logic            overrun;

    always_comb begin
        timer_live = (tcnt < TC_LIM);
        stop_hit   = tick_en && (state == ST_SHIFT) && check_at_gate
                     && clk_hi && clk_rise && timer_live;
        overrun    = tick_en && (state != ST_IDLE) && !timer_live;

        ctl.load   = tick_en && (state == ST_IDLE) && kbd_ready && link_ready;
        ctl.preset = tick_en && (state == ST_PRESET);
        ctl.clear  = tick_en && (state == ST_PRESET) && (rcnt == RC_LAST);
        ctl.shift  = tick_en && (state == ST_SHIFT) && clk_hi && clk_rise
                     && !check_at_gate;
        ctl.stop   = stop_hit || overrun;

        cycle_busy = (state != ST_IDLE);
        run        = (state == ST_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rcnt  <= '0;
            tcnt  <= '0;
        end else if (tick_en) begin
            unique case (state)
                ST_IDLE: begin
                    if (ctl.load) begin
                        state <= ST_PRESET;
                        rcnt  <= '0;
                        tcnt  <= '0;
                    end
                end
                ST_PRESET: begin
                    tcnt <= tcnt + 1'b1;
                    rcnt <= rcnt + 1'b1;
                    if (overrun)        state <= ST_IDLE;
                    else if (ctl.clear) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    tcnt <= tcnt + 1'b1;
                    if (ctl.stop) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/kst_shift_reg.sv
module kst_shift_reg
    import kst_pkg::*;
#(
    parameter int unsigned DATA_W     = 7,
    parameter bit          PARITY_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  sr_ctrl_t          ctl,
    input  logic [DATA_W-1:0] char_in,
    output logic              line_out,
    output logic              reg_empty,
    output logic              check_at_gate
);
    localparam int unsigned FRAME_W = DATA_W + 1;   // start bit plus data
    localparam int unsigned NS_W    = $clog2(FRAME_W + 1);
    localparam logic [NS_W-1:0] NS_FULL = NS_W'(FRAME_W);
    localparam logic [NS_W-1:0] NS_LAST = NS_W'(FRAME_W - 1);

    logic [DATA_W-1:0]  data_q;
    logic [FRAME_W-1:0] sreg;
    logic [NS_W-1:0]    nsent;
    logic               par_q;
    logic               line_q;
    logic               empty_q;
    logic               gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            sreg    <= '1;
            nsent   <= '0;
            par_q   <= 1'b0;
            line_q  <= 1'b1;
            empty_q <= 1'b1;
            gate_q  <= 1'b0;
        end else begin
            if (ctl.load) begin
                data_q  <= char_in;
                empty_q <= 1'b0;
            end
            if (ctl.preset) begin
                sreg   <= '1;
                par_q  <= 1'b0;
                gate_q <= 1'b0;
                nsent  <= '0;
            end
            if (ctl.clear) begin
                // Ones survive the preset; zeros (and the start slot) are cleared.
                sreg  <= {FRAME_W{1'b1}} & {data_q, 1'b0};
                par_q <= check_bit(MAX_DATA_W'(data_q), DATA_W, PARITY_ODD);
            end
            if (ctl.shift) begin
                if (nsent < NS_FULL) begin
                    line_q <= sreg[0];
                    sreg   <= {1'b0, sreg[FRAME_W-1:1]};
                    nsent  <= nsent + 1'b1;
                    if (nsent == NS_LAST) empty_q <= 1'b1;
                end else begin
                    line_q <= par_q;
                    gate_q <= 1'b1;
                end
            end
            if (ctl.stop) begin
                line_q  <= 1'b1;
                gate_q  <= 1'b0;
                empty_q <= 1'b1;
            end
        end
    end

    always_comb begin
        line_out      = line_q;
        reg_empty     = empty_q;
        check_at_gate = gate_q;
    end

endmodule

// File: rtl/keychar_serial_tx.sv
module keychar_serial_tx
    import kst_pkg::*;
#(
    parameter int unsigned DATA_W      = 7,
    parameter int unsigned BIT_TICKS   = 8,
    parameter int unsigned PULSE_TICKS = 2,
    parameter int unsigned RST_TICKS   = 3,
    parameter bit          PARITY_ODD  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              kbd_ready,
    input  logic              link_ready,
    input  logic [DATA_W-1:0] char_in,
    output logic              line_out,
    output logic              cycle_busy,
    output logic              reg_empty
);
    localparam int unsigned FRAME_W = DATA_W + 1;

    sr_ctrl_t ctl;
    logic     run;
    logic     clk_hi;
    logic     clk_rise;
    logic     check_at_gate;

    kst_bit_clock #(
        .BIT_TICKS   (BIT_TICKS),
        .PULSE_TICKS (PULSE_TICKS)
    ) u_bclk (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .run      (run),
        .clk_hi   (clk_hi),
        .clk_rise (clk_rise)
    );

    kst_cycle_ctrl #(
        .RST_TICKS (RST_TICKS),
        .BIT_TICKS (BIT_TICKS),
        .FRAME_W   (FRAME_W)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .tick_en       (tick_en),
        .kbd_ready     (kbd_ready),
        .link_ready    (link_ready),
        .clk_hi        (clk_hi),
        .clk_rise      (clk_rise),
        .check_at_gate (check_at_gate),
        .cycle_busy    (cycle_busy),
        .run           (run),
        .ctl           (ctl)
    );

    kst_shift_reg #(
        .DATA_W     (DATA_W),
        .PARITY_ODD (PARITY_ODD)
    ) u_sreg (
        .clk           (clk),
        .rst           (rst),
        .ctl           (ctl),
        .char_in       (char_in),
        .line_out      (line_out),
        .reg_empty     (reg_empty),
        .check_at_gate (check_at_gate)
    );

endmodule

// File: rtl/kst_checker.sv
module kst_checker (
    input logic clk,
    input logic rst,
    input logic tick_en,
    input logic kbd_ready,
    input logic link_ready,
    input logic line_out,
    input logic cycle_busy,
    input logic reg_empty,
    input logic check_at_gate,
    input logic clk_hi
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !cycle_busy |-> line_out);  // R8

    AST_IDLE_REG_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !cycle_busy |-> reg_empty);  // R7

    AST_START_NEEDS_LINK: assert property (@(posedge clk) disable iff (rst)
        $rose(cycle_busy) |-> $past(link_ready && kbd_ready && tick_en));  // R3

    AST_FROZEN_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(line_out) && $stable(cycle_busy) && $stable(reg_empty)));  // R10

    AST_STOP_AT_GATE: assert property (@(posedge clk) disable iff (rst)
        $fell(cycle_busy) |-> $past(check_at_gate && clk_hi));  // R8

endmodule

bind keychar_serial_tx kst_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_en       (tick_en),
    .kbd_ready     (kbd_ready),
    .link_ready    (link_ready),
    .line_out      (line_out),
    .cycle_busy    (cycle_busy),
    .reg_empty     (reg_empty),
    .check_at_gate (check_at_gate),
    .clk_hi        (clk_hi)
);

// File: tb/keychar_serial_tx_tb_top.sv
`timescale 1ns/1ps
module keychar_serial_tx_tb_top;
    localparam int DW    = 7;
    localparam int BT    = 8;
    localparam int PT    = 2;
    localparam int RT    = 3;
    localparam bit PODD  = 1'b0;
    localparam int TOTAL = RT + 1 + (DW + 2) * BT;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic          kbd_ready = 1'b0;
    logic          link_ready = 1'b1;
    logic [DW-1:0] char_in = '0;
    logic          line_out;
    logic          cycle_busy;
    logic          reg_empty;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    keychar_serial_tx #(
        .DATA_W (DW), .BIT_TICKS (BT), .PULSE_TICKS (PT),
        .RST_TICKS (RT), .PARITY_ODD (PODD)
    ) dut_i (
        .clk (clk), .rst (rst), .tick_en (tick_en), .kbd_ready (kbd_ready),
        .link_ready (link_ready), .char_in (char_in), .line_out (line_out),
        .cycle_busy (cycle_busy), .reg_empty (reg_empty)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Expected outputs n ticks after the load tick (n = 0 is the load tick).
    task automatic expect_at(input int n, input logic [DW-1:0] d,
                             output logic el, output logic eb, output logic ee,
                             output string rq);
        int k;
        if (n >= TOTAL) begin
            el = 1'b1; eb = 1'b0; ee = 1'b1; rq = "R8";
        end else if (n <= RT) begin
            el = 1'b1; eb = 1'b1; ee = 1'b0; rq = "R4";
        end else begin
            k  = (n - RT - 1) / BT;
            eb = 1'b1;
            ee = (k >= DW);
            if (k == 0) begin
                el = 1'b0; rq = "R4";
            end else if (k <= DW) begin
                el = d[k-1]; rq = "R5";
            end else begin
                el = (^d) ^ PODD; rq = "R6";
            end
        end
    endtask

    // One tick, optionally preceded by idle cycles; ends on a falling edge.
    task automatic step(input bit gaps);
        int g;
        g = gaps ? int'($urandom_range(0, 2)) : 0;
        repeat (g) @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic run_frame(input logic [DW-1:0] d, input bit keep_kbd,
                             input bit gaps, input bit freeze);
        logic el, eb, ee;
        logic s_line, s_busy, s_empty;
        string rq;
        char_in   = d;
        kbd_ready = 1'b1;
        step(gaps);
        chk("R2", "busy after load tick", cycle_busy, 1'b1);
        chk("R7", "empty falls on load", reg_empty, 1'b0);
        chk("R4", "line high on load tick", line_out, 1'b1);
        if (keep_kbd) char_in = ~d;      // R9: must not disturb this frame
        else          kbd_ready = 1'b0;
        for (int n = 1; n <= TOTAL; n++) begin
            step(gaps);
            expect_at(n, d, el, eb, ee, rq);
            chk(rq, "line", line_out, el);
            chk(keep_kbd ? "R9" : "R8", "busy", cycle_busy, eb);
            chk("R7", "empty", reg_empty, ee);
            if (freeze && n == 20) begin
                s_line = line_out; s_busy = cycle_busy; s_empty = reg_empty;
                repeat (5) @(negedge clk);
                chk("R10", "line frozen", line_out, s_line);
                chk("R10", "busy frozen", cycle_busy, s_busy);
                chk("R10", "empty frozen", reg_empty, s_empty);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "line after reset", line_out, 1'b1);
        chk("R1", "busy after reset", cycle_busy, 1'b0);
        chk("R1", "empty after reset", reg_empty, 1'b1);

        // R3: link not ready blocks a start.
        link_ready = 1'b0;
        kbd_ready  = 1'b1;
        char_in    = 7'h2A;
        for (int i = 0; i < 6; i++) begin
            step(1'b1);
            chk("R3", "no start without link", cycle_busy, 1'b0);
            chk("R3", "line idle without link", line_out, 1'b1);
        end
        kbd_ready  = 1'b0;
        link_ready = 1'b1;
        step(1'b0);
        chk("R2", "no start without keyboard ready", cycle_busy, 1'b0);

        // Directed corner characters.
        run_frame(7'h00, 1'b0, 1'b0, 1'b0);
        run_frame(7'h7F, 1'b0, 1'b0, 1'b1);
        run_frame(7'h55, 1'b0, 1'b1, 1'b0);

        // R9: keyboard ready held through a cycle, then immediate reload.
        run_frame(7'h13, 1'b1, 1'b1, 1'b0);
        run_frame(~7'h13, 1'b0, 1'b1, 1'b0);

        // Random characters with random tick gaps.
        for (int i = 0; i < 10; i++) begin
            d = DW'($urandom);
            run_frame(d, (i % 4) == 1, 1'b1, (i % 3) == 0);
            if ((i % 4) == 1) run_frame(~d, 1'b0, 1'b1, 1'b0);
            repeat ($urandom_range(0, 3)) step(1'b1);
            chk("R8", "idle between frames", cycle_busy, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule